// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a memory-mapped watchdog with a 32-bit down-counter clocked by the core clock. Software programs a reload value, then sets the enable bit. The counter then counts down once per cycle. When it runs out the first time, it raises an interrupt and reloads itself. If software has not cleared that interrupt by the time the counter runs out again, and reset generation is enabled, the block raises a reset request. The request stays high until the block itself is reset.

Software services the watchdog by writing any value to the clear register. That write drops the pending interrupt and restarts the countdown from the reload value. A key-protected lock register sits beside the others. Writing the key opens the other registers for writing. Writing any other value closes them again, and while they are closed, writes to them are dropped. The bus is a simple one: an address, a write enable and write data, with read data returned combinationally.

Top module: `twostage_wdog`

## Requirements
- R1: Out of reset the block is unlocked and disabled. The reload value reads 0xFFFFFFFF, the counter reads 0xFFFFFFFF, no interrupt is pending, `irqOut` and `rstReqOut` are low, and the lock register (offset 0xC00) reads 0.
- R2: A write of 0x1ACCE551 to offset 0xC00 unlocks the block. A write of any other value to that offset locks it. While locked, reading 0xC00 returns 1 in bit 0.
- R3: While locked, writes to the reload (0x000), control (0x008) and clear (0x00C) offsets have no effect.
- R4: In the control register at 0x008, bit 0 is the counter enable and bit 1 is reset enable. Bits 31:2 read as zero. Every unlocked control write with bit 0 set loads the counter from the reload value.
- R5: While enabled, the counter, read at 0x004, drops by one each clock cycle. While disabled, it holds its value.
- R6: An enabled counter at zero expires on the next cycle: the raw interrupt status (bit 0 at 0x010) is set and the counter is reloaded. With reload value L, the interrupt appears L+1 cycles after the enabling write.
- R7: An expiry that occurs while the raw interrupt is already pending raises `rstReqOut` if reset enable is set, and leaves it low if reset enable is clear. Once high, `rstReqOut` stays high until the block is reset.
- R8: Any unlocked write to offset 0x00C clears the pending interrupt and reloads the counter from the reload value.
- R9: The masked status (bit 0 at 0x014) equals the raw status ANDed with the enable bit, and `irqOut` follows the masked status.
- R10: A write to the reload value while the counter runs leaves the current count unchanged. The new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busAddr | input | 12 | Register byte offset |
| busWrEn | input | 1 | Write strobe for one cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr` |
| irqOut | output | 1 | Masked interrupt |
| rstReqOut | output | 1 | Sticky reset request |

## Verification
The bench counts cycles from the enabling write and samples exactly where the first expiry should appear, and again at the second. A design that is off by one in its zero detection would raise the interrupt a cycle early or a cycle late. A design that resets on the first expiry, or ignores reset enable, would raise `rstReqOut` at the wrong time. The bench also writes the reload value mid-count: a design that copies that write into the counter would show the new value at once. Finally, it writes while locked, disables with an interrupt pending, and clears before the second expiry. These steps expose a lock that leaks writes, a masked status that ignores the enable bit, and a clear that fails to restart the count.

// File: rtl/twostage_wdog_pkg.sv
`timescale 1ns/1ps
package twostage_wdog_pkg;
  localparam int OffLoad  = 'h000;
  localparam int OffCount = 'h004;
  localparam int OffCtrl  = 'h008;
  localparam int OffClr   = 'h00C;
  localparam int OffRaw   = 'h010;
  localparam int OffMask  = 'h014;
  localparam int OffLock  = 'hC00;

  // strobes and levels from the register file to the counter datapath
  typedef struct packed {
    logic enable;
    logic rstEn;
    logic reloadStb;
    logic clearStb;
  } wdogCmd_t;
endpackage

// File: rtl/twostage_wdog_regs.sv
`timescale 1ns/1ps
module twostage_wdog_regs
  import twostage_wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic [DATA_W-1:0] cntVal,
  input  logic              rawPend,
  output wdogCmd_t          cmd,
  output logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut
);
  localparam logic [ADDR_W-1:0] AddrLoad  = ADDR_W'(OffLoad);
  localparam logic [ADDR_W-1:0] AddrCount = ADDR_W'(OffCount);
  localparam logic [ADDR_W-1:0] AddrCtrl  = ADDR_W'(OffCtrl);
  localparam logic [ADDR_W-1:0] AddrClr   = ADDR_W'(OffClr);
  localparam logic [ADDR_W-1:0] AddrRaw   = ADDR_W'(OffRaw);
  localparam logic [ADDR_W-1:0] AddrMask  = ADDR_W'(OffMask);
  localparam logic [ADDR_W-1:0] AddrLock  = ADDR_W'(OffLock);

  logic              locked;
  logic [DATA_W-1:0] loadReg;
  logic              enReg;
  logic              rstEnReg;
  logic              wrOpen;
  logic              hitLoad, hitCtrl, hitClr, hitLock;
  logic              maskedSt;

  assign wrOpen  = busWrEn && !locked;
  assign hitLoad = (busAddr == AddrLoad);
  assign hitCtrl = (busAddr == AddrCtrl);
  assign hitClr  = (busAddr == AddrClr);
  assign hitLock = (busAddr == AddrLock);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked   <= 1'b0;
      loadReg  <= '1;
      enReg    <= 1'b0;
      rstEnReg <= 1'b0;
    end else begin
      if (busWrEn && hitLock) locked <= (busWrData != UNLOCK_KEY);
      if (wrOpen && hitLoad) loadReg <= busWrData;
      if (wrOpen && hitCtrl) begin
        enReg    <= busWrData[0];
        rstEnReg <= busWrData[1];
      end
    end
  end

  always_comb begin
    cmd.enable    = enReg;
    cmd.rstEn     = rstEnReg;
    cmd.reloadStb = wrOpen && hitCtrl && busWrData[0];
    cmd.clearStb  = wrOpen && hitClr;
  end

  assign loadVal  = loadReg;
  assign maskedSt = rawPend & enReg;
  assign irqOut   = maskedSt;

  always_comb begin
    busRdData = '0;
    unique case (busAddr)
      AddrLoad:  busRdData = loadReg;
      AddrCount: busRdData = cntVal;
      AddrCtrl:  busRdData = {{(DATA_W-2){1'b0}}, rstEnReg, enReg};
      AddrRaw:   busRdData = {{(DATA_W-1){1'b0}}, rawPend};
      AddrMask:  busRdData = {{(DATA_W-1){1'b0}}, maskedSt};
      AddrLock:  busRdData = {{(DATA_W-1){1'b0}}, locked};
      default:   busRdData = '0;
    endcase
  end

  // R3: a locked block keeps its reload value and control bits
  a_r3_locked_hold: assert property (@(posedge clk) disable iff (!rstN)
    (locked && busWrEn && !hitLock) |=> ($stable(loadReg) && $stable(enReg) && $stable(rstEnReg)));

  // R3: no strobe reaches the datapath while locked
  a_r3_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (!cmd.reloadStb && !cmd.clearStb));

  // R2: the key opens the block
  a_r2_key_unlocks: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && hitLock && busWrData == UNLOCK_KEY) |=> !locked);

  // R2: any other value closes it
  a_r2_other_locks: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && hitLock && busWrData != UNLOCK_KEY) |=> locked);
endmodule

// File: rtl/twostage_wdog_core.sv
`timescale 1ns/1ps
module twostage_wdog_core
  import twostage_wdog_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdogCmd_t          cmd,
  input  logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] cntVal,
  output logic              rawPend,
  output logic              rstReq
);
  logic anyStb;
  logic atZero;
  logic expire;

  assign anyStb = cmd.reloadStb || cmd.clearStb;
  assign atZero = (cntVal == '0);
  assign expire = cmd.enable && atZero && !anyStb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal  <= '1;
      rawPend <= 1'b0;
      rstReq  <= 1'b0;
    end else begin
      if (cmd.clearStb) begin
        cntVal  <= loadVal;
        rawPend <= 1'b0;
      end else if (cmd.reloadStb) begin
        cntVal <= loadVal;
      end else if (expire) begin
        cntVal  <= loadVal;
        rawPend <= 1'b1;
        if (rawPend && cmd.rstEn) rstReq <= 1'b1;
      end else if (cmd.enable) begin
        cntVal <= cntVal - 1'b1;
      end
    end
  end

  // R6: an expiry raises the raw interrupt and reloads the counter
  a_r6_expiry: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> (rawPend && cntVal == $past(loadVal)));

  // R5: the counter steps down by one while it runs
  a_r5_step: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.enable && !atZero && !anyStb) |=> (cntVal == $past(cntVal) - 1'b1));

  // R5: the counter holds while disabled
  a_r5_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.enable && !anyStb) |=> $stable(cntVal));

  // R7: the reset request is sticky
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> rstReq);

  // R7: the reset request needs a pending interrupt and reset enable
  a_r7_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstReq) |-> $past(rawPend && cmd.rstEn));

  // R8: a clear write drops the interrupt and reloads the counter
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clearStb |=> (!rawPend && cntVal == $past(loadVal)));
endmodule

// File: rtl/twostage_wdog.sv
`timescale 1ns/1ps
module twostage_wdog
  import twostage_wdog_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 12,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              irqOut,
  output logic              rstReqOut
);
  wdogCmd_t          cmd;
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] cntVal;
  logic              rawPend;

  twostage_wdog_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .UNLOCK_KEY(UNLOCK_KEY)
  ) u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .cntVal(cntVal), .rawPend(rawPend),
    .cmd(cmd), .loadVal(loadVal), .busRdData(busRdData), .irqOut(irqOut)
  );

  twostage_wdog_core #(.DATA_W(DATA_W)) u_core (
    .clk(clk), .rstN(rstN), .cmd(cmd), .loadVal(loadVal),
    .cntVal(cntVal), .rawPend(rawPend), .rstReq(rstReqOut)
  );
endmodule

// File: tb/twostage_wdog_tb.sv
`timescale 1ns/1ps
module twostage_wdog_tb;
  logic        clk = 1'b0;
  logic        rstN;
  logic [11:0] busAddr;
  logic        busWrEn;
  logic [31:0] busWrData;
  logic [31:0] busRdData;
  logic        irqOut;
  logic        rstReqOut;

  int checks = 0;
  int fails  = 0;

  localparam logic [31:0] Key = 32'h1ACC_E551;

  always #4 clk = ~clk;  // 125 MHz

  twostage_wdog u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqOut(irqOut),
    .rstReqOut(rstReqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // one cycle: the write lands on the posedge inside this call
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic testResetState();
    logic [31:0] d;
    doReset();
    rd(12'h000, d); chk("R1 load", d, 32'hFFFF_FFFF);
    rd(12'h004, d); chk("R1 count", d, 32'hFFFF_FFFF);
    rd(12'h008, d); chk("R1 ctrl", d, 0);
    rd(12'h010, d); chk("R1 raw", d, 0);
    rd(12'hC00, d); chk("R1 lock", d, 0);
    chk("R1 irqOut", irqOut, 0);
    chk("R1 rstReqOut", rstReqOut, 0);
  endtask

  task automatic testLock();
    logic [31:0] d;
    doReset();
    wr(12'hC00, 32'h0);
    rd(12'hC00, d); chk("R2 locked reads 1", d, 1);
    wr(12'h000, 32'd7);
    wr(12'h008, 32'd3);
    wr(12'h00C, 32'd1);
    rd(12'h000, d); chk("R3 load ignored", d, 32'hFFFF_FFFF);
    rd(12'h008, d); chk("R3 ctrl ignored", d, 0);
    rd(12'h004, d); chk("R3 count untouched", d, 32'hFFFF_FFFF);
    wr(12'hC00, Key);
    rd(12'hC00, d); chk("R2 key unlocks", d, 0);
    wr(12'h000, 32'd7);
    rd(12'h000, d); chk("R2 write after unlock", d, 7);
    wr(12'hC00, Key ^ 32'h1);
    rd(12'hC00, d); chk("R2 near-key locks", d, 1);
  endtask

  task automatic testCtrlFields();
    logic [31:0] d;
    doReset();
    wr(12'h000, 32'd40);
    wr(12'h008, 32'hFFFF_FFFF);
    rd(12'h008, d); chk("R4 reserved bits zero", d, 3);
    rd(12'h004, d); chk("R4 enable reloads", d, 40);
    wr(12'h008, 32'h0);
    rd(12'h004, d); chk("R5 one step before disable", d, 39);
    waitCyc(5);
    rd(12'h004, d); chk("R5 hold while disabled", d, 39);
  endtask

  task automatic testFirstExpiry();
    logic [31:0] d;
    doReset();
    wr(12'h000, 32'd5);
    wr(12'h008, 32'd1);
    rd(12'h004, d); chk("R4 count after enable", d, 5);
    waitCyc(2);
    rd(12'h004, d); chk("R5 countdown", d, 3);
    waitCyc(3);
    rd(12'h004, d); chk("R6 at zero", d, 0);
    rd(12'h010, d); chk("R6 raw not yet", d, 0);
    chk("R6 irq not yet", irqOut, 0);
    waitCyc(1);
    rd(12'h010, d); chk("R6 raw set", d, 1);
    rd(12'h004, d); chk("R6 reloaded", d, 5);
    chk("R9 irqOut high", irqOut, 1);
    rd(12'h014, d); chk("R9 masked set", d, 1);
    wr(12'h008, 32'd0);
    rd(12'h014, d); chk("R9 masked off when disabled", d, 0);
    rd(12'h010, d); chk("R9 raw kept when disabled", d, 1);
    chk("R9 irqOut low when disabled", irqOut, 0);
  endtask

  task automatic testSecondExpiry();
    logic [31:0] d;
    doReset();
    wr(12'h000, 32'd5);
    wr(12'h008, 32'd3);
    waitCyc(6);
    chk("R7 no reset on first expiry", rstReqOut, 0);
    waitCyc(5);
    chk("R7 no reset before second", rstReqOut, 0);
    waitCyc(1);
    chk("R7 reset on second expiry", rstReqOut, 1);
    wr(12'h008, 32'd0);
    wr(12'h00C, 32'd0);
    waitCyc(3);
    chk("R7 reset sticky", rstReqOut, 1);
    // reset enable clear: no reset
    doReset();
    wr(12'h000, 32'd5);
    wr(12'h008, 32'd1);
    waitCyc(14);
    chk("R7 no reset without enable", rstReqOut, 0);
    rd(12'h010, d); chk("R7 raw pending", d, 1);
  endtask

  task automatic testClear();
    logic [31:0] d;
    doReset();
    wr(12'h000, 32'd5);
    wr(12'h008, 32'd3);
    waitCyc(8);
    rd(12'h010, d); chk("R8 raw before clear", d, 1);
    wr(12'h00C, 32'hDEAD_BEEF);
    rd(12'h010, d); chk("R8 raw cleared", d, 0);
    rd(12'h004, d); chk("R8 count reloaded", d, 5);
    waitCyc(6);
    chk("R8 cleared expiry no reset", rstReqOut, 0);
    rd(12'h010, d); chk("R8 raw again", d, 1);
    wr(12'hC00, 32'h0);
    wr(12'h00C, 32'h1);
    rd(12'h010, d); chk("R3 clear ignored when locked", d, 1);
  endtask

  task automatic testLoadLive();
    logic [31:0] d;
    doReset();
    wr(12'h000, 32'd20);
    wr(12'h008, 32'd1);
    waitCyc(3);
    wr(12'h000, 32'd4);
    rd(12'h004, d); chk("R10 count untouched", d, 16);
    waitCyc(16);
    rd(12'h004, d); chk("R10 reaches zero", d, 0);
    waitCyc(1);
    rd(12'h004, d); chk("R10 new load at reload", d, 4);
    rd(12'h010, d); chk("R6 raw after live load", d, 1);
  endtask

  initial begin
    rstN = 1'b0; busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    fork
      begin
        testResetState();
        testLock();
        testCtrlFields();
        testFirstExpiry();
        testSecondExpiry();
        testClear();
        testLoadLive();
      end
      begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule